// File: doc/BRIEF.md
# Delay-Slot Next-PC Sequencer

This block holds the three-entry program-counter chain of a 32-bit processor whose control transfers take effect after a branch delay slot. The three registers are the address being executed (`pc`), the next one (`npc`) and the one after that (`nnpc`). Each cycle the decode stage presents one request. The request carries a transfer kind, the outcome of the condition test, a sign-extended byte displacement, a register operand, a 26-bit absolute-jump field and a link flag. The block works out where the chain moves next and steps all three registers on the clock edge.

A redirecting transfer does not replace the address that is already in flight. The instruction in the slot after a branch still executes, and the new target enters the chain one position later. The likely-branch kind is the one exception. When it is not taken, the chain jumps past the delay slot, and an annul pulse tells downstream logic to drop that slot's writeback. For a request that links, the block emits a write of the current `nnpc` into general register 31. This is the return address past the delay slot. A stall freezes the chain and blocks both the link write and the annul pulse.

Top module: `dslot_pc_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the chain loads `pc = rst_vec`, `npc = rst_vec + 4` and `nnpc = rst_vec + 8`, all modulo 2^32.
- R2: Transfer kinds are encoded on `xfer_kind` as 0 = none, 1 = conditional branch, 2 = likely branch, 3 = register jump and 4 = absolute jump. Codes 5 to 7 act as none. With no transfer and no stall, the step is `pc <= npc`, `npc <= nnpc`, `nnpc <= nnpc + 4`.
- R3: A branch of kind 1 or 2 with `cond_true = 1` steps `pc <= npc`, `npc <= npc + disp`, `nnpc <= npc + disp + 4`.
- R4: A kind-1 branch with `cond_true = 0` takes the R2 sequential step, so its delay slot still runs, and `annul` stays low.
- R5: A kind-2 branch with `cond_true = 0` steps `pc <= nnpc`, `npc <= nnpc + 4`, `nnpc <= nnpc + 8`. It raises `annul` in the same cycle as the request. `annul` is low in every other case.
- R6: A kind-3 jump targets `rs_val` with bit 1 cleared and bit 0 replaced by bit 0 of `pc + 4`. The chain steps `pc <= npc`, `npc <= target`, `nnpc <= target + 4`, and `cond_true` is ignored.
- R7: A kind-4 jump targets the top 4 bits of `pc + 4` in bits 31:28, `imm_field` in bits 27:2 and zeros in bits 1:0. It steps the chain as in R6 and ignores `cond_true`.
- R8: When `link_req = 1`, the kind is 1 to 4 and `stall = 0`, `link_wr_en` is high in that cycle with `link_wr_idx = 31` and `link_wr_data` equal to the current `nnpc`, whatever `cond_true` is. For kinds 0 and 5 to 7, `link_req` is ignored.
- R9: The link write does not change the chain update. A register jump uses `rs_val` as presented, even while it links into register 31.
- R10: While `stall` is high, all three chain registers hold, and `link_wr_en` and `annul` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_vec | input | 32 | Address loaded into `pc` at reset |
| stall | input | 1 | Freezes the chain and blocks side effects |
| xfer_kind | input | 3 | Transfer kind code |
| cond_true | input | 1 | Branch condition outcome |
| disp | input | 32 | Sign-extended byte displacement for branches |
| rs_val | input | 32 | Register operand for register jumps |
| imm_field | input | 26 | Word-index field for absolute jumps |
| link_req | input | 1 | Request a return-address write |
| pc | output | 32 | Address being executed |
| npc | output | 32 | Next address (delay slot after a branch) |
| nnpc | output | 32 | Address after `npc` |
| link_wr_en | output | 1 | Link-register write strobe |
| link_wr_idx | output | 5 | Link-register index (31) |
| link_wr_data | output | 32 | Return address to write |
| annul | output | 1 | Drop writeback of the skipped delay slot |

## Verification
Every transfer code from 0 to 7 is crossed with both condition values, both link values, stall on and off, and positive, negative and zero displacements. This sweep separates the taken redirect from the two not-taken paths: the normal one keeps the delay slot and the likely one skips it. The sweep runs from three reset vectors. An odd vector exposes the mode bit kept by register jumps. A vector just below a 256 MB boundary exercises the region bits of absolute jumps. A vector near the top of memory makes every adder wrap. Register operands carry set low bits, so the alignment mask can be seen. Jumps that link at the same time show that the operand, not the link value, steers the target.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

    localparam int XLEN     = 32;
    localparam int IMM_W    = 26;
    localparam int REGION_W = 4;
    localparam int RIDX_W   = 5;
    localparam int LINK_REG = 31;
    localparam int KIND_W   = 3;
    localparam int ALIGN_W  = XLEN - REGION_W - IMM_W;

    typedef logic [XLEN-1:0] addr_t;

    localparam addr_t WORD_STEP = addr_t'(4);

    typedef enum logic [KIND_W-1:0] {
        XK_NONE = 3'd0,
        XK_BR   = 3'd1,
        XK_BRL  = 3'd2,
        XK_JREG = 3'd3,
        XK_JABS = 3'd4
    } xfer_kind_e;

    typedef struct packed {
        addr_t pc;
        addr_t npc;
        addr_t nnpc;
    } pc_chain_t;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic              cond;
        addr_t             disp;
        addr_t             rs;
        logic [IMM_W-1:0]  imm;
        logic              link;
    } xfer_req_t;

    function automatic pc_chain_t chain_from_vec(addr_t v);
        pc_chain_t c;
        c.pc   = v;
        c.npc  = v + WORD_STEP;
        c.nnpc = v + WORD_STEP + WORD_STEP;
        return c;
    endfunction

    function automatic pc_chain_t chain_redirect(pc_chain_t cur, addr_t tgt);
        pc_chain_t c;
        c.pc   = cur.npc;
        c.npc  = tgt;
        c.nnpc = tgt + WORD_STEP;
        return c;
    endfunction

    function automatic logic kind_is_xfer(logic [KIND_W-1:0] k);
        return (k >= KIND_W'(XK_BR)) && (k <= KIND_W'(XK_JABS));
    endfunction

endpackage

// File: rtl/dslot_target.sv
module dslot_target
    import dslot_pkg::*;
(
    input  pc_chain_t cur,
    input  xfer_req_t req,
    output pc_chain_t nxt,
    output logic      skip_slot
);

    addr_t pc_plus4;
    addr_t br_tgt;
    addr_t jr_tgt;
    addr_t ja_tgt;
    pc_chain_t seq_step;
    pc_chain_t skip_step;

    assign pc_plus4 = cur.pc + WORD_STEP;
    assign br_tgt   = cur.npc + req.disp;
    assign jr_tgt   = {req.rs[XLEN-1:2], 1'b0, pc_plus4[0]};
    assign ja_tgt   = {pc_plus4[XLEN-1 -: REGION_W], req.imm, {ALIGN_W{1'b0}}};

    always_comb begin
        seq_step.pc   = cur.npc;
        seq_step.npc  = cur.nnpc;
        seq_step.nnpc = cur.nnpc + WORD_STEP;

        skip_step.pc   = cur.nnpc;
        skip_step.npc  = cur.nnpc + WORD_STEP;
        skip_step.nnpc = cur.nnpc + WORD_STEP + WORD_STEP;
    end

    always_comb begin
        nxt       = seq_step;
        skip_slot = 1'b0;
        case (xfer_kind_e'(req.kind))
            XK_BR: begin
                if (req.cond) nxt = chain_redirect(cur, br_tgt);
            end
            XK_BRL: begin
                if (req.cond) begin
                    nxt = chain_redirect(cur, br_tgt);
                end else begin
                    nxt       = skip_step;
                    skip_slot = 1'b1;
                end
            end
            XK_JREG: nxt = chain_redirect(cur, jr_tgt);
            XK_JABS: nxt = chain_redirect(cur, ja_tgt);
            default: nxt = seq_step;
        endcase
    end

endmodule

// File: rtl/dslot_link.sv
module dslot_link
    import dslot_pkg::*;
(
    input  xfer_req_t         req,
    input  logic              stall,
    input  addr_t             ret_addr,
    output logic              wr_en,
    output logic [RIDX_W-1:0] wr_idx,
    output addr_t             wr_data
);

    assign wr_en   = req.link && kind_is_xfer(req.kind) && !stall;
    assign wr_idx  = RIDX_W'(LINK_REG);
    assign wr_data = ret_addr;

endmodule

// File: rtl/dslot_chain.sv
module dslot_chain
    import dslot_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  addr_t     rst_vec,
    input  logic      stall,
    input  pc_chain_t nxt,
    output pc_chain_t cur
);

    pc_chain_t chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= chain_from_vec(rst_vec);
        end else if (!stall) begin
            chain_q <= nxt;
        end
    end

    assign cur = chain_q;

    p_hold_on_stall_r10: assert property (@(posedge clk) disable iff (rst)
        stall |=> (cur == $past(cur)));

endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
    import dslot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   rst_vec,
    input  logic              stall,
    input  logic [KIND_W-1:0] xfer_kind,
    input  logic              cond_true,
    input  logic [XLEN-1:0]   disp,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic              link_req,
    output logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   npc,
    output logic [XLEN-1:0]   nnpc,
    output logic              link_wr_en,
    output logic [RIDX_W-1:0] link_wr_idx,
    output logic [XLEN-1:0]   link_wr_data,
    output logic              annul
);

    xfer_req_t req;
    pc_chain_t cur;
    pc_chain_t nxt;
    logic      skip_slot;

    always_comb begin
        req.kind = xfer_kind;
        req.cond = cond_true;
        req.disp = disp;
        req.rs   = rs_val;
        req.imm  = imm_field;
        req.link = link_req;
    end

    dslot_target u_target (
        .cur       (cur),
        .req       (req),
        .nxt       (nxt),
        .skip_slot (skip_slot)
    );

    dslot_chain u_chain (
        .clk     (clk),
        .rst     (rst),
        .rst_vec (rst_vec),
        .stall   (stall),
        .nxt     (nxt),
        .cur     (cur)
    );

    dslot_link u_link (
        .req      (req),
        .stall    (stall),
        .ret_addr (cur.nnpc),
        .wr_en    (link_wr_en),
        .wr_idx   (link_wr_idx),
        .wr_data  (link_wr_data)
    );

    assign pc    = cur.pc;
    assign npc   = cur.npc;
    assign nnpc  = cur.nnpc;
    assign annul = skip_slot && !stall;

    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!stall && xfer_kind == 3'd0) |=>
        (pc == $past(npc) && npc == $past(nnpc) && nnpc == $past(nnpc) + WORD_STEP));

    p_slot_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (!stall && !annul) |=> (pc == $past(npc)));

    p_annul_cause_r5: assert property (@(posedge clk) disable iff (rst)
        annul |-> (xfer_kind == 3'd2 && !cond_true && !stall));

    p_jreg_align_r6: assert property (@(posedge clk) disable iff (rst)
        (!stall && xfer_kind == 3'd3) |=> (npc[1] == 1'b0 && npc[0] == $past(pc[0])));

    p_link_value_r8: assert property (@(posedge clk) disable iff (rst)
        link_wr_en |-> (link_wr_data == nnpc && link_wr_idx == RIDX_W'(LINK_REG)));

    p_stall_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!link_wr_en && !annul));

endmodule

// File: tb/dslot_pc_seq_test.sv
module dslot_pc_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rst_vec = 32'h0000_1000;
    logic        stall = 1'b0;
    logic [2:0]  xfer_kind = 3'd0;
    logic        cond_true = 1'b0;
    logic [31:0] disp = 32'd0;
    logic [31:0] rs_val = 32'd0;
    logic [25:0] imm_field = 26'd0;
    logic        link_req = 1'b0;
    logic [31:0] pc, npc, nnpc, link_wr_data;
    logic        link_wr_en, annul;
    logic [4:0]  link_wr_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] mp, mn, mnn;

    always #2.5 clk = ~clk;

    dslot_pc_seq uut (
        .clk(clk), .rst(rst), .rst_vec(rst_vec), .stall(stall),
        .xfer_kind(xfer_kind), .cond_true(cond_true), .disp(disp),
        .rs_val(rs_val), .imm_field(imm_field), .link_req(link_req),
        .pc(pc), .npc(npc), .nnpc(nnpc), .link_wr_en(link_wr_en),
        .link_wr_idx(link_wr_idx), .link_wr_data(link_wr_data), .annul(annul)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    function automatic string kind_tag(input logic [2:0] k, input logic c, input logic s);
        if (s) return "R10";
        case (k)
            3'd1: return c ? "R3" : "R4";
            3'd2: return c ? "R3" : "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic do_reset(input logic [31:0] v);
        @(negedge clk);
        rst = 1'b1;
        rst_vec = v;
        stall = 1'b0;
        xfer_kind = 3'd0;
        link_req = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mp = v; mn = v + 32'd4; mnn = v + 32'd8;
        chk("R1 pc", pc, mp);
        chk("R1 npc", npc, mn);
        chk("R1 nnpc", nnpc, mnn);
    endtask

    task automatic step(input logic [2:0] k, input logic c, input logic [31:0] d,
                        input logic [31:0] r, input logic [25:0] im,
                        input logic l, input logic s);
        logic [31:0] p4, tgt, ep, en, enn;
        logic        exp_link, exp_annul;
        string       tag;
        xfer_kind = k; cond_true = c; disp = d; rs_val = r;
        imm_field = im; link_req = l; stall = s;
        #1;
        exp_link  = !s && l && (k >= 3'd1) && (k <= 3'd4);
        exp_annul = !s && (k == 3'd2) && !c;
        chk(exp_link ? "R8 link_en" : "R8 link_en ignored", {31'd0, link_wr_en}, {31'd0, exp_link});
        if (exp_link) begin
            chk("R8 link_data", link_wr_data, mnn);
            chk("R8 link_idx", {27'd0, link_wr_idx}, 32'd31);
        end
        chk(s ? "R10 annul" : "R5 annul", {31'd0, annul}, {31'd0, exp_annul});
        p4 = mp + 32'd4;
        ep = mn; en = mnn; enn = mnn + 32'd4;
        tgt = 32'd0;
        case (k)
            3'd1, 3'd2: begin
                if (c) begin
                    tgt = mn + d; en = tgt; enn = tgt + 32'd4;
                end else if (k == 3'd2) begin
                    ep = mnn; en = mnn + 32'd4; enn = mnn + 32'd8;
                end
            end
            3'd3: begin
                tgt = {r[31:2], 1'b0, p4[0]}; en = tgt; enn = tgt + 32'd4;
            end
            3'd4: begin
                tgt = {p4[31:28], im, 2'b00}; en = tgt; enn = tgt + 32'd4;
            end
            default: ;
        endcase
        if (s) begin
            ep = mp; en = mn; enn = mnn;
        end
        tag = kind_tag(k, c, s);
        @(posedge clk);
        @(negedge clk);
        mp = ep; mn = en; mnn = enn;
        chk({tag, (l && !s) ? " R9 pc" : " pc"}, pc, mp);
        chk({tag, (l && !s) ? " R9 npc" : " npc"}, npc, mn);
        chk({tag, " nnpc"}, nnpc, mnn);
    endtask

    initial begin
        for (int cyc = 0; cyc < 190000; cyc++) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] vecs [3];
        logic [31:0] disps [4];
        vecs[0] = 32'h0000_1000;
        vecs[1] = 32'h0FFF_FFE1;
        vecs[2] = 32'hFFFF_FFE4;
        disps[0] = 32'h0000_0010;
        disps[1] = 32'hFFFF_FFF8;
        disps[2] = 32'h0000_0000;
        disps[3] = 32'h0000_7FFC;
        for (int vi = 0; vi < 3; vi++) begin
            do_reset(vecs[vi]);
            for (int k = 0; k < 8; k++)
                for (int c = 0; c < 2; c++)
                    for (int l = 0; l < 2; l++)
                        for (int s = 0; s < 2; s++)
                            for (int di = 0; di < 4; di++)
                                step(3'(k), 1'(c), disps[di],
                                     32'h8000_0003 ^ (disps[di] << 4) ^ 32'(k << 8),
                                     26'h2A5_A5A ^ disps[di][25:0],
                                     1'(l), 1'(s));
        end
        // R9: register jump through the link register while linking
        do_reset(32'h0000_2001);
        step(3'd3, 1'b0, 32'd0, 32'h0000_4003, 26'd0, 1'b1, 1'b0);
        chk("R9 jump operand kept", npc, 32'h0000_4001);
        finish_run();
    end

endmodule